// File: doc/BRIEF.md
# Dual-Channel Periodic Interrupt Timer

This block raises interrupts at fixed intervals on two independent channels. Both channels count the same 1 ms tick. Software first writes an 8-bit period, in milliseconds, into a channel's period register. It then pulses that channel's attach strobe. The attach copies the register into a working period, clears the elapsed count and starts the channel. From then on, the channel raises one event every time the elapsed count reaches the working period. It keeps doing so until a detach pulse arrives or the run-mode input drops.

Every event goes into a small pending queue of channel numbers. The queue is served one entry at a time through a valid/acknowledge pair. Entries are presented only while the global interrupt enable is high. While that enable is low, the channels keep running and their events keep filling the queue. When the queue is full, any further event is discarded and a sticky overflow flag is set.

Top module: `periodic_irq_timer`

## Requirements
- R1: At an accepted attach, the channel copies its period register into a working period. Later writes to the period register do not change the event spacing until the next attach.
- R2: After an accepted attach with working period N, the first event arrives on the N-th tick. Each later event arrives exactly N ticks after the one before it. The event is pushed at the clock edge that samples the tick, so irqValid can rise right after that edge.
- R3: Attaching a channel that is already running discards its elapsed count and restarts timing from zero, using the period register's current value.
- R4: A detach pulse stops its channel. A low runMode stops both channels and rejects any attach that arrives while it is low. A channel that was stopped stays stopped when runMode returns high, until it is attached again.
- R5: An attach is ignored when the channel's period register holds 0. A channel attached in that way raises no events.
- R6: While globalIrqEn is low, irqValid stays low, irqAck has no effect, and expirations are still added to the queue. When the enable returns, the queued entries are presented in order.
- R7: The queue is first-in first-out. irqId is the channel number, 0 or 1. When both channels expire on the same tick, channel 0's entry is queued ahead of channel 1's.
- R8: The queue holds 4 entries. An expiration that finds no free slot is dropped and sets overflow. overflow then stays high until reset. Filling the queue exactly, with no drop, leaves overflow low.
- R9: irqValid is high whenever the queue is not empty and globalIrqEn is high. While irqValid is high, irqId shows the oldest entry. Each cycle in which irqValid and irqAck are both high removes exactly one entry.
- R10: After reset, both channels are stopped, both period registers hold 0, the queue is empty, irqValid is low and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickMs | input | 1 | One-cycle pulse marking each millisecond |
| runMode | input | 1 | Channels may run only while this input is high |
| periodWrEn | input | 1 | Period register write strobe |
| periodWrSel | input | 1 | Channel whose period register is written |
| periodWrData | input | 8 | Period value in ms (0 is illegal) |
| attach | input | 2 | Per-channel attach pulse |
| detach | input | 2 | Per-channel detach pulse |
| globalIrqEn | input | 1 | Global interrupt enable |
| irqAck | input | 1 | Removes the presented entry from the queue |
| irqValid | output | 1 | A queued event is being presented |
| irqId | output | 1 | Channel number of the presented event |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The bench goes after several corner cases, each of which a faulty design would reveal in a specific way:
- **Off-by-one terminal count.** A design that compares against the wrong count fires one tick early or one tick late. The bench catches this by checking irqValid on the tick just before the period ends and on the tick at which it ends.
- **Period not latched at attach.** A design that reads the live period register changes its spacing after a write.
- **Count not cleared on re-attach.** A design that keeps the old count fires too soon after a re-attach.
- **Wrong order on a shared tick.** Both channels are made to expire on the same tick. A design that gets the order wrong presents channel 1 first, and the scoreboard reports the mismatch.
- **Masking that stops the channels.** Events are produced while globalIrqEn is low and must all come out once it returns. A design that stops counting, or that drops events while masked, leaves the scoreboard short.
- **Queue overflow.** Both channels run with period 1 and nobody acknowledges. The bench checks three things: a queue of exactly four entries does not raise overflow, the fifth and sixth events are lost, and the flag stays set after the queue drains.
- **Rejected attaches.** A zero period, or a low runMode, must reject an attach. A design that accepts such an attach produces events that the scoreboard does not expect.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIT_CH   = 2;
  localparam int PIT_ID_W = (PIT_CH > 1) ? $clog2(PIT_CH) : 1;

  typedef struct packed {
    logic [PIT_CH-1:0] load;   // capture period, clear elapsed count
    logic [PIT_CH-1:0] run;    // channel counts ticks this cycle
    logic              pop;    // remove head entry of the queue
  } pitStrobe_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              runMode,
  input  logic [PIT_CH-1:0] attach,
  input  logic [PIT_CH-1:0] detach,
  input  logic [PIT_CH-1:0] periodZero,
  input  logic              globalIrqEn,
  input  logic              irqAck,
  input  logic              fifoEmpty,
  output pitStrobe_t        strobe,
  output logic              irqValid
);
  logic [PIT_CH-1:0] active;
  logic [PIT_CH-1:0] stopNow;
  logic [PIT_CH-1:0] loadNow;

  // Stopping dominates; a zero period or a low run mode rejects the attach.
  always_comb begin
    stopNow  = detach | {PIT_CH{~runMode}};
    loadNow  = attach & ~periodZero & ~stopNow;
    irqValid = ~fifoEmpty & globalIrqEn;
    strobe.load = loadNow;
    strobe.run  = active & ~stopNow & ~loadNow;
    strobe.pop  = irqValid & irqAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= '0;
    else       active <= (active & ~stopNow) | loadNow;
  end

  assert_run_mode_stops_R4: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |=> (active == '0));

  assert_detach_stops_R4: assert property (@(posedge clk) disable iff (!rstN)
    (detach != '0) |=> ((active & $past(detach)) == '0));

  assert_zero_attach_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((attach & periodZero & ~active) != '0) |=> ((active & $past(attach & periodZero & ~active)) == '0));

  assert_pop_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !globalIrqEn |-> !irqValid);
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int DEPTH    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickMs,
  input  logic                periodWrEn,
  input  logic [PIT_ID_W-1:0] periodWrSel,
  input  logic [PERIOD_W-1:0] periodWrData,
  input  pitStrobe_t          strobe,
  output logic [PIT_CH-1:0]   periodZero,
  output logic                fifoEmpty,
  output logic [PIT_ID_W-1:0] headId,
  output logic                overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PIT_CH-1:0] expire;

  // ---------------- per-channel timers ----------------
  for (genvar c = 0; c < PIT_CH; c++) begin : g_chan
    logic [PERIOD_W-1:0] periodReg;
    logic [PERIOD_W-1:0] workPeriod;
    logic [PERIOD_W-1:0] elapsed;
    logic                hit;

    assign hit          = (elapsed + 1'b1) == workPeriod;
    assign expire[c]    = strobe.run[c] & tickMs & hit;
    assign periodZero[c] = (periodReg == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) periodReg <= '0;
      else if (periodWrEn && periodWrSel == PIT_ID_W'(c)) periodReg <= periodWrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        workPeriod <= '0;
        elapsed    <= '0;
      end else if (strobe.load[c]) begin
        workPeriod <= periodReg;
        elapsed    <= '0;
      end else if (strobe.run[c] && tickMs) begin
        elapsed <= hit ? '0 : elapsed + 1'b1;
      end
    end

    assert_run_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
      strobe.run[c] |-> (workPeriod != '0));

    assert_elapsed_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.run[c] |-> (elapsed < workPeriod));
  end

  // ---------------- pending queue ----------------
  logic [PIT_ID_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]    rdPtr, wrPtr;
  logic [CNT_W-1:0]    fill;
  logic [PIT_CH-1:0]   pushMask;
  logic [PTR_W-1:0]    pushIdx [PIT_CH];
  logic                dropAny;
  int                  accepted;

  // Channels are visited in index order, so channel 0 takes the earlier slot.
  always_comb begin
    int space;
    space    = DEPTH - int'(fill) + (strobe.pop ? 1 : 0);
    accepted = 0;
    dropAny  = 1'b0;
    for (int c = 0; c < PIT_CH; c++) begin
      pushMask[c] = 1'b0;
      pushIdx[c]  = wrPtr + PTR_W'(accepted);
      if (expire[c]) begin
        if (accepted < space) begin
          pushMask[c] = 1'b1;
          accepted    = accepted + 1;
        end else begin
          dropAny = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < PIT_CH; c++)
      if (pushMask[c]) slots[pushIdx[c]] <= PIT_ID_W'(c);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(accepted);
      if (strobe.pop) rdPtr <= rdPtr + 1'b1;
      fill  <= CNT_W'(int'(fill) + accepted - (strobe.pop ? 1 : 0));
      if (dropAny) overflow <= 1'b1;
    end
  end

  assign fifoEmpty = (fill == '0);
  assign headId    = slots[rdPtr];

  assert_fill_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(DEPTH));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_head_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEmpty && !strobe.pop) |=> $stable(headId));
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
  import pit_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickMs,
  input  logic                runMode,
  input  logic                periodWrEn,
  input  logic [PIT_ID_W-1:0] periodWrSel,
  input  logic [PERIOD_W-1:0] periodWrData,
  input  logic [PIT_CH-1:0]   attach,
  input  logic [PIT_CH-1:0]   detach,
  input  logic                globalIrqEn,
  input  logic                irqAck,
  output logic                irqValid,
  output logic [PIT_ID_W-1:0] irqId,
  output logic                overflow
);
  pitStrobe_t        strobe;
  logic [PIT_CH-1:0] periodZero;
  logic              fifoEmpty;

  pit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runMode(runMode), .attach(attach), .detach(detach),
    .periodZero(periodZero), .globalIrqEn(globalIrqEn), .irqAck(irqAck),
    .fifoEmpty(fifoEmpty), .strobe(strobe), .irqValid(irqValid)
  );

  pit_datapath #(.PERIOD_W(PERIOD_W), .DEPTH(QUEUE_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .periodWrEn(periodWrEn),
    .periodWrSel(periodWrSel), .periodWrData(periodWrData), .strobe(strobe),
    .periodZero(periodZero), .fifoEmpty(fifoEmpty), .headId(irqId),
    .overflow(overflow)
  );
endmodule

// File: tb/periodic_irq_timer_bench.sv
module periodic_irq_timer_bench;
  import pit_pkg::*;

  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic       rstN, tickMs, runMode, periodWrEn, globalIrqEn, irqAck;
  logic [0:0] periodWrSel;
  logic [7:0] periodWrData;
  logic [1:0] attach, detach;
  logic       irqValid, overflow;
  logic [0:0] irqId;

  periodic_irq_timer u_periodic_irq_timer (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .runMode(runMode),
    .periodWrEn(periodWrEn), .periodWrSel(periodWrSel), .periodWrData(periodWrData),
    .attach(attach), .detach(detach), .globalIrqEn(globalIrqEn), .irqAck(irqAck),
    .irqValid(irqValid), .irqId(irqId), .overflow(overflow)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int expQ[$];
  int mReg[2], mPer[2], mCnt[2];
  bit mAct[2];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Scoreboard monitor, sampling on the falling edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (irqValid && !globalIrqEn) check(0, "R6", "irqValid while masked", 1, 0);
      if (irqValid && irqAck) begin
        if (expQ.size() == 0) check(0, "R9", "unexpected event id", int'(irqId), -1);
        else begin
          int e;
          e = expQ.pop_front();
          check(int'(irqId) == e, "R7", "event channel order", int'(irqId), e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writePeriod(int ch, int val);
    periodWrEn = 1; periodWrSel = 1'(ch); periodWrData = 8'(val);
    mReg[ch] = val;
    cyc(1);
    periodWrEn = 0;
  endtask

  task automatic doAttach(logic [1:0] mask);
    attach = mask;
    for (int ch = 0; ch < 2; ch++)
      if (mask[ch] && runMode && mReg[ch] != 0) begin
        mAct[ch] = 1; mPer[ch] = mReg[ch]; mCnt[ch] = 0;
      end
    cyc(1);
    attach = '0;
  endtask

  task automatic doDetach(logic [1:0] mask);
    detach = mask;
    for (int ch = 0; ch < 2; ch++) if (mask[ch]) mAct[ch] = 0;
    cyc(1);
    detach = '0;
  endtask

  task automatic setRun(logic v);
    runMode = v;
    if (!v) begin mAct[0] = 0; mAct[1] = 0; end
    cyc(1);
  endtask

  task automatic tick();
    tickMs = 1;
    for (int ch = 0; ch < 2; ch++)
      if (mAct[ch]) begin
        mCnt[ch]++;
        if (mCnt[ch] == mPer[ch]) begin
          mCnt[ch] = 0;
          if (expQ.size() < DEPTH) expQ.push_back(ch);
        end
      end
    cyc(1);
    tickMs = 0;
    cyc(2);
  endtask

  initial begin
    rstN = 0; tickMs = 0; runMode = 0; periodWrEn = 0; periodWrSel = '0;
    periodWrData = '0; attach = '0; detach = '0; globalIrqEn = 0; irqAck = 0;
    cyc(3);
    rstN = 1;
    cyc(1);
    check(irqValid == 0, "R10", "irqValid after reset", int'(irqValid), 0);
    check(overflow == 0, "R10", "overflow after reset", int'(overflow), 0);

    // R10 / R5: period registers reset to 0, so the attach is rejected
    runMode = 1; globalIrqEn = 1;
    doAttach(2'b01);
    repeat (3) tick();
    check(irqValid == 0, "R5", "no event with reset period", int'(irqValid), 0);

    // R2: first event on the 3rd tick
    writePeriod(0, 3);
    doAttach(2'b01);
    tick(); tick();
    check(irqValid == 0, "R2", "no event before period", int'(irqValid), 0);
    tick();
    check(irqValid == 1, "R2", "event at period", int'(irqValid), 1);
    check(irqId == 0, "R2", "event channel", int'(irqId), 0);
    irqAck = 1; cyc(2);
    check(irqValid == 0, "R9", "queue drained by ack", int'(irqValid), 0);

    // R2: exact spacing of the next event
    irqAck = 0;
    tick(); tick();
    check(irqValid == 0, "R2", "spacing early", int'(irqValid), 0);
    tick();
    check(irqValid == 1, "R2", "spacing exact", int'(irqValid), 1);
    irqAck = 1; cyc(2);

    // R1: a write after attach leaves the spacing unchanged
    writePeriod(0, 5);
    irqAck = 0;
    tick(); tick();
    check(irqValid == 0, "R1", "old period early", int'(irqValid), 0);
    tick();
    check(irqValid == 1, "R1", "old period kept", int'(irqValid), 1);
    irqAck = 1; cyc(2);

    // R3: re-attach mid-count restarts with the new period
    irqAck = 0;
    tick();
    writePeriod(0, 4);
    doAttach(2'b01);
    tick(); tick(); tick();
    check(irqValid == 0, "R3", "count cleared by re-attach", int'(irqValid), 0);
    tick();
    check(irqValid == 1, "R3", "new period used", int'(irqValid), 1);
    irqAck = 1; cyc(2);

    // R7: both channels expire on the same tick
    irqAck = 0;
    writePeriod(0, 5); writePeriod(1, 5);
    doAttach(2'b11);
    repeat (5) tick();
    check(irqValid == 1 && irqId == 0, "R7", "channel 0 at head", int'(irqId), 0);
    irqAck = 1; cyc(3);
    check(irqValid == 0, "R9", "both entries removed", int'(irqValid), 0);

    // R6: expirations keep queuing while masked
    globalIrqEn = 0;
    repeat (5) tick();
    check(irqValid == 0, "R6", "masked no valid", int'(irqValid), 0);
    globalIrqEn = 1; cyc(3);
    check(irqValid == 0, "R6", "masked events delivered", int'(irqValid), 0);

    // R8: overflow when six events meet a queue of four
    irqAck = 0;
    doDetach(2'b11);
    writePeriod(0, 1); writePeriod(1, 1);
    doAttach(2'b11);
    tick(); tick();
    check(overflow == 0, "R8", "exactly full, no overflow", int'(overflow), 0);
    tick();
    check(overflow == 1, "R8", "overflow on drop", int'(overflow), 1);
    irqAck = 1; cyc(6);
    check(expQ.size() == 0, "R8", "four kept entries delivered", expQ.size(), 0);
    check(overflow == 1, "R8", "overflow sticky", int'(overflow), 1);

    // R4: detach, run mode off, attach while run mode off
    doDetach(2'b01);
    repeat (3) tick();
    setRun(0);
    irqAck = 0; cyc(2);
    repeat (3) tick();
    check(irqValid == 0, "R4", "run mode off stops channels", int'(irqValid), 0);
    doAttach(2'b01);
    tick(); tick();
    check(irqValid == 0, "R4", "attach rejected when not running", int'(irqValid), 0);
    setRun(1);
    tick(); tick();
    check(irqValid == 0, "R4", "stopped channels stay stopped", int'(irqValid), 0);

    // R5: zero period written explicitly
    writePeriod(1, 0);
    doAttach(2'b10);
    repeat (3) tick();
    check(irqValid == 0, "R5", "zero period attach ignored", int'(irqValid), 0);

    irqAck = 1; cyc(4);
    check(expQ.size() == 0, "R9", "scoreboard empty at end", expQ.size(), 0);
    summary();
  end
endmodule